// File: doc/BRIEF.md
# RTC Periodic Interrupt and Flag Unit

This block produces the periodic timing events and the square-wave output of a real-time clock. It counts a 32.768 kHz tick-enable on a divider chain and takes one tap of that chain as the periodic event. A 4-bit rate code in the first control register picks the tap, from 32768 Hz down to 2 Hz. A three-bit divider-mode field in the same register either runs the chain, holds it cleared, or stops it.

A second control register holds the interrupt enables and the square-wave enable. A status byte collects three event flags: periodic, alarm and update-ended. The alarm and update-ended pulses come from the time-keeping core. The status byte also reports whether any flag is set whose enable is on, and that summary drives an active-high interrupt line. The status byte can always be observed. When the host pulses a read strobe, the flags clear after that cycle.

Top module: `rtc_irq_unit`

## Requirements
- R1: With divider mode 3'b010 (write-data bits 6:4 on a control-A write) and rate code c from 1 to 15 (bits 3:0), a periodic event occurs once every 2^(c-1) ticks, giving 65536 >> c Hz from a 32768 Hz tick. The first event after leaving divider reset comes on the 2^(c-1)-th tick.
- R2: Rate code 0 produces no periodic events, and `sqw` is held low.
- R3: Divider modes 3'b110 and 3'b111 hold the chain at zero and produce no periodic events. Leaving them restarts the count from zero.
- R4: For codes 2 to 15, `sqw` is a 50 % square wave with a period of 2^(c-1) ticks. It is low for the first half-period after a restart, so after k ticks it equals bit (c-2) of k. For code 1, `sqw` is high for the one clock after each tick.
- R5: `sqw` is low whenever the square-wave enable (control-B bit 3) is 0.
- R6: In `c_data`, bit 6 is the periodic flag, bit 5 the alarm flag and bit 4 the update-ended flag. Bits 3:0 read 0. Each flag is set by its event whatever the enable setting, and it stays set until cleared.
- R7: `c_data` bit 7 and `irq` are 1 exactly when some flag is set and its enable is on. The enables are control-B bit 6 for periodic, bit 5 for alarm and bit 4 for update-ended.
- R8: `c_data` shows the flags in the same cycle as `rd_c`. After that clock edge, all flags read 0.
- R9: An event that arrives in the same cycle as `rd_c` leaves its flag set after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-clock 32.768 kHz tick enable |
| wr_a | input | 1 | Write strobe for control A (mode, rate) |
| wr_b | input | 1 | Write strobe for control B (enables) |
| wr_data | input | 8 | Write data for control A or B |
| alarm_evt | input | 1 | Alarm-match pulse from the time core |
| update_evt | input | 1 | Update-ended pulse from the time core |
| rd_c | input | 1 | Status-byte read strobe (clears the flags) |
| c_data | output | 8 | Status byte {summary, periodic, alarm, update, 0000} |
| irq | output | 1 | Interrupt request, active high |
| sqw | output | 1 | Square-wave output |

## Verification
The bench sweeps all fifteen rate codes from a divider restart and counts ticks up to the first and second periodic flag. A tap that is off by one stage would double or halve that count. On every tick it also compares `sqw` with the expected counter bit, which catches a wrong or inverted tap and a wave that does not restart at zero. Further checks cover code 0, the square-wave enable being off, and both hold modes under continuous ticks, where a leaking event would set the periodic flag. Flag checks cover an event with its enable off, which must set the flag but raise no interrupt, and enabling afterwards, which must raise it. They also cover read-then-clear, and an alarm pulse in the same cycle as the read, which a naive clear would lose.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int RATE_W   = 4;
    localparam int MAX_CODE = (1 << RATE_W) - 1;
    localparam int DIV_W    = MAX_CODE;
    localparam int NFLAG    = 3;

    localparam logic [2:0] DV_RUN = 3'b010;

    typedef struct packed {
        logic [2:0]        dv;
        logic [RATE_W-1:0] rate;
    } ctrl_a_t;

    typedef struct packed {
        logic pie;
        logic aie;
        logic uie;
        logic sqwe;
    } ctrl_b_t;

    function automatic logic dv_held(input logic [2:0] dv);
        return dv[2:1] == 2'b11;
    endfunction

    // low (code-1) bits set; zero for code 0 and code 1
    function automatic logic [DIV_W-1:0] tap_mask(input logic [RATE_W-1:0] code);
        logic [DIV_W-1:0] m;
        for (int i = 0; i < DIV_W; i++)
            m[i] = (32'(i) + 32'd1) < 32'(code);
        return m;
    endfunction

endpackage

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
    import rtc_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_a,
    input  logic       wr_b,
    input  logic [7:0] wr_data,
    output ctrl_a_t    a_q,
    output ctrl_b_t    b_q
);
    logic unused_bits;
    assign unused_bits = ^{wr_data[7], wr_data[2:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            if (wr_a) a_q <= ctrl_a_t'(wr_data[6:0]);
            if (wr_b) b_q <= ctrl_b_t'(wr_data[6:3]);
        end
    end
endmodule

// File: rtl/rtc_rate_div.sv
module rtc_rate_div
    import rtc_irq_pkg::*;
#(
    parameter int DW = DIV_W,
    parameter int RW = RATE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic [2:0]    dv,
    input  logic [RW-1:0] rate,
    input  logic          sqw_en,
    output logic          per_evt,
    output logic          sqw
);
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] mask;
    logic          tick_q;
    logic          run;
    logic          held;
    logic          phase;

    assign run  = (dv == DV_RUN);
    assign held = dv_held(dv);
    assign mask = tap_mask(rate);

    always_ff @(posedge clk) begin
        if (rst || held) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            if (run && tick_en) cnt_q <= cnt_q + 1'b1;
            tick_q <= run && tick_en;
        end
    end

    assign per_evt = run && tick_en && (rate != '0) && ((cnt_q & mask) == mask);

    always_comb begin
        phase = tick_q;
        for (int i = 0; i < DW - 1; i++)
            if (32'(rate) == i + 2) phase = cnt_q[i];
    end

    assign sqw = sqw_en && (rate != '0) && phase;

    // R3
    held_no_evt_chk: assert property (@(posedge clk) disable iff (rst)
        held |-> !per_evt);
    // R3
    held_clears_chk: assert property (@(posedge clk) disable iff (rst)
        held |=> (cnt_q == '0));
    // R1
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        (per_evt && rate >= 2) |=> (!per_evt || rate != $past(rate)));
    // R2
    code0_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rate == '0) |-> (!per_evt && !sqw));
endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg
    import rtc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_clr,
    input  logic [NFLAG-1:0] ev,
    input  logic [NFLAG-1:0] en,
    output logic [NFLAG-1:0] flags_q,
    output logic             irqf
);
    always_ff @(posedge clk) begin
        if (rst)         flags_q <= '0;
        else if (rd_clr) flags_q <= ev;
        else             flags_q <= flags_q | ev;
    end

    assign irqf = |(flags_q & en);

    // R9
    keep_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && ev != '0) |=> ((flags_q & $past(ev)) == $past(ev)));
    // R8
    clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && ev == '0) |=> (flags_q == '0));
    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
    // R7
    idle_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_q == '0) |-> !irqf);
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
    import rtc_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       wr_a,
    input  logic       wr_b,
    input  logic [7:0] wr_data,
    input  logic       alarm_evt,
    input  logic       update_evt,
    input  logic       rd_c,
    output logic [7:0] c_data,
    output logic       irq,
    output logic       sqw
);
    ctrl_a_t          a_q;
    ctrl_b_t          b_q;
    logic             per_evt;
    logic [NFLAG-1:0] flags;
    logic             irqf;

    rtc_ctrl_regs u_regs (
        .clk(clk), .rst(rst), .wr_a(wr_a), .wr_b(wr_b),
        .wr_data(wr_data), .a_q(a_q), .b_q(b_q)
    );

    rtc_rate_div #(.DW(DIV_W), .RW(RATE_W)) u_div (
        .clk(clk), .rst(rst), .tick_en(tick_en), .dv(a_q.dv),
        .rate(a_q.rate), .sqw_en(b_q.sqwe), .per_evt(per_evt), .sqw(sqw)
    );

    rtc_flag_reg u_flags (
        .clk(clk), .rst(rst), .rd_clr(rd_c),
        .ev({per_evt, alarm_evt, update_evt}),
        .en({b_q.pie, b_q.aie, b_q.uie}),
        .flags_q(flags), .irqf(irqf)
    );

    assign c_data = {irqf, flags, 4'b0000};
    assign irq    = irqf;

    // R5
    sqw_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !b_q.sqwe |-> !sqw);
endmodule

// File: tb/tb_rtc_irq_unit.sv
module tb_rtc_irq_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       wr_a = 1'b0;
    logic       wr_b = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       alarm_evt = 1'b0;
    logic       update_evt = 1'b0;
    logic       rd_c = 1'b0;
    logic [7:0] c_data;
    logic       irq;
    logic       sqw;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    rtc_irq_unit dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_a(wr_a), .wr_b(wr_b),
        .wr_data(wr_data), .alarm_evt(alarm_evt), .update_evt(update_evt),
        .rd_c(rd_c), .c_data(c_data), .irq(irq), .sqw(sqw)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_a(input logic [7:0] d);
        @(negedge clk); wr_a = 1'b1; wr_data = d;
        @(negedge clk); wr_a = 1'b0;
    endtask

    task automatic write_b(input logic [7:0] d);
        @(negedge clk); wr_b = 1'b1; wr_data = d;
        @(negedge clk); wr_b = 1'b0;
    endtask

    task automatic read_c(output logic [7:0] v);
        @(negedge clk); rd_c = 1'b1; #1 v = c_data;
        @(negedge clk); rd_c = 1'b0;
    endtask

    task automatic ticks_quiet(input int n, input string req);
        @(negedge clk); tick_en = 1'b1;
        for (int k = 1; k <= n; k++) begin
            @(posedge clk); @(negedge clk);
            chk(req, {31'd0, sqw}, 32'd0);
        end
        tick_en = 1'b0;
        chk(req, {31'd0, c_data[6]}, 32'd0);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("reset c_data", {24'd0, c_data}, 32'h00);
        chk("reset irq", {31'd0, irq}, 32'd0);
        chk("reset sqw", {31'd0, sqw}, 32'd0);

        // R1 R3 R4: sweep every rate code from a divider restart
        for (int c = 1; c <= 15; c++) begin
            int n;
            n = 1 << (c - 1);
            write_a(8'h70);
            write_b(8'h48);
            read_c(v);
            write_a(8'h20 | 8'(c));
            for (int rep = 0; rep < 2; rep++) begin
                @(negedge clk); tick_en = 1'b1;
                for (int k = 1; k <= n; k++) begin
                    @(posedge clk); @(negedge clk);
                    if (c >= 2 && rep == 0)
                        chk("R4 sqw phase", {31'd0, sqw}, 32'((k >> (c - 2)) & 1));
                    if (k == n - 1 || k == n)
                        chk("R1 periodic flag timing", {31'd0, c_data[6]}, 32'(k == n));
                end
                tick_en = 1'b0;
                chk("R7 irq on periodic", {31'd0, irq}, 32'd1);
                chk("R6 status byte", {24'd0, c_data}, 32'hC0);
                read_c(v);
            end
        end

        // R4 code 1: high for one clock after a tick
        write_a(8'h70); write_a(8'h21); write_b(8'h08);
        @(negedge clk); tick_en = 1'b1;
        @(negedge clk); tick_en = 1'b0;
        chk("R4 code1 sqw high", {31'd0, sqw}, 32'd1);
        @(negedge clk);
        chk("R4 code1 sqw low", {31'd0, sqw}, 32'd0);
        read_c(v);

        // R2 code 0
        write_a(8'h20); write_b(8'h48);
        ticks_quiet(40, "R2 code0");
        // R5 enable off
        write_a(8'h70); write_a(8'h23); write_b(8'h40);
        @(negedge clk); tick_en = 1'b1;
        for (int k = 1; k <= 16; k++) begin
            @(posedge clk); @(negedge clk);
            chk("R5 sqw gated", {31'd0, sqw}, 32'd0);
        end
        tick_en = 1'b0;
        read_c(v);
        // R3 hold modes
        write_b(8'h48);
        write_a(8'h71);
        ticks_quiet(30, "R3 hold 111");
        write_a(8'h61);
        ticks_quiet(30, "R3 hold 110");

        // R6 R7: flag without enable, then enable
        write_b(8'h00);
        @(negedge clk); alarm_evt = 1'b1;
        @(negedge clk); alarm_evt = 1'b0;
        chk("R6 alarm flag w/o enable", {24'd0, c_data}, 32'h20);
        chk("R7 no irq w/o enable", {31'd0, irq}, 32'd0);
        write_b(8'h20);
        chk("R7 irq after enable", {31'd0, irq}, 32'd1);
        chk("R7 summary bit", {24'd0, c_data}, 32'hA0);
        // R8 read returns then clears
        read_c(v);
        chk("R8 read value", {24'd0, v}, 32'hA0);
        chk("R8 cleared", {24'd0, c_data}, 32'h00);
        chk("R8 irq dropped", {31'd0, irq}, 32'd0);
        // update flag with enable
        write_b(8'h10);
        @(negedge clk); update_evt = 1'b1;
        @(negedge clk); update_evt = 1'b0;
        chk("R6 update flag", {24'd0, c_data}, 32'h90);
        // R9 event during read
        @(negedge clk); rd_c = 1'b1; alarm_evt = 1'b1;
        @(negedge clk); rd_c = 1'b0; alarm_evt = 1'b0;
        chk("R9 alarm kept on read", {24'd0, c_data}, 32'h20);
        chk("R9 no irq alarm disabled", {31'd0, irq}, 32'd0);
        read_c(v);
        chk("R8 final clear", {24'd0, c_data}, 32'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule